// File: doc/BRIEF.md
# Slotted Trigger-Object Output Serializer

This block takes the sorted set of up to five trigger objects that the algorithm logic produces for each bunch crossing and plays them out one per cycle on a fast output clock. That clock runs at seven times the crossing rate. Each crossing therefore owns a frame of seven output slots. Slots 0 to 4 carry the five objects in sorted order, and slots 5 and 6 are always idle. A single-cycle start pulse marks slot 0 of every frame.

A free-running slot counter in the output domain is tied to the crossing boundary by an alignment strobe. The strobe comes from the slower domain and is expected while the counter is at a fixed phase offset. The whole object set, its per-object empty flags and the 12-bit crossing number are sampled once per frame, in slot 6. Input data only has to stay stable around that one edge. The crossing number is then presented beside the object stream for the whole following frame.

Top module: `tob_slot_serializer`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, tobValid, tobStart, locked and misalign are low, and tobData and bcnOut are zero.
- R2: Until the first alignment strobe has been seen, tobStart and tobValid stay low in every slot.
- R3: Without a strobe, slotIdx counts 0, 1, ..., 6 and wraps to 0. A strobe sampled in any cycle makes the next cycle slot 6 (alignment phase 5, plus one).
- R4: Once locked, slot k (k = 0..4) carries object k, which occupies bits [k*OBJ_W +: OBJ_W] of objData, with tobValid high.
- R5: In slots 5 and 6, tobData is zero and tobValid is low.
- R6: When bit k of objEmpty was set at capture, slot k of the following frame has tobData zero and tobValid low.
- R7: Once locked, tobStart is high for exactly one cycle per frame, in slot 0.
- R8: objData, objEmpty and bcnIn are sampled only at the clock edge that ends slot 6. Changes in other slots do not affect the frame being sent.
- R9: bcnOut takes the bcnIn value sampled with the object set and changes only on entry to slot 0.
- R10: A strobe arriving while locked, when slotIdx is not 5, sets misalign. misalign then stays set until reset. A strobe arriving in slot 5 leaves misalign unchanged.
- R11: The first alignment strobe after reset never sets misalign, whatever slot it lands in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-domain clock, seven cycles per crossing |
| rstN | input | 1 | Active-low synchronous reset |
| alignPulse | input | 1 | Crossing-boundary strobe, expected in slot 5 |
| objData | input | NUM_OBJ*OBJ_W (160) | Sorted objects, object k in bits [k*OBJ_W +: OBJ_W] |
| objEmpty | input | NUM_OBJ (5) | Per-object empty flag |
| bcnIn | input | BCN_W (12) | Crossing number for the object set |
| tobData | output | OBJ_W (32) | Object word of the current slot, zero when idle |
| tobValid | output | 1 | Current slot carries an object |
| tobStart | output | 1 | Slot 0 marker |
| slotIdx | output | 3 | Current slot number 0..6 |
| bcnOut | output | BCN_W (12) | Crossing number of the frame being sent |
| locked | output | 1 | At least one alignment strobe seen since reset |
| misalign | output | 1 | Sticky: a later strobe landed off phase |

## Verification
The hardest situations to reach from the ports are a strobe that lands off phase after lock, and an input change in the middle of a frame. Both need the stimulus to know the current slot, so the bench first steps the free-running counter to a chosen slotIdx and only then raises the strobe or swaps the inputs. For the off-phase case it then checks that the frame restarts from slot 6 with misalign set. For the mid-frame case it checks that the frame already in flight keeps its captured objects and crossing number, and that the swapped values appear in the next frame.

// File: rtl/tob_slot_pkg.sv
package tob_slot_pkg;
  localparam int FRAME_SLOTS = 7;
  localparam int SLOT_W = $clog2(FRAME_SLOTS);

  typedef struct packed {
    logic              capture;
    logic              emit;
    logic              start;
    logic [SLOT_W-1:0] slotSel;
  } slot_strobe_t;
endpackage

// File: rtl/tob_slot_ctrl.sv
module tob_slot_ctrl
  import tob_slot_pkg::*;
#(
  parameter int NUM_OBJ     = 5,
  parameter int ALIGN_PHASE = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         alignPulse,
  output slot_strobe_t strobe,
  output logic         locked,
  output logic         misalign
);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SLOT_W-1:0] PHASE_SLOT = SLOT_W'(ALIGN_PHASE);
  localparam logic [SLOT_W-1:0] ALIGN_NEXT = SLOT_W'((ALIGN_PHASE + 1) % FRAME_SLOTS);

  logic [SLOT_W-1:0] slotQ;
  logic [SLOT_W-1:0] slotD;
  logic              offPhase;

  assign offPhase = alignPulse && locked && (slotQ != PHASE_SLOT);

  always_comb begin
    if (alignPulse)              slotD = ALIGN_NEXT;
    else if (slotQ == LAST_SLOT) slotD = '0;
    else                         slotD = slotQ + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ    <= '0;
      locked   <= 1'b0;
      misalign <= 1'b0;
    end else begin
      slotQ <= slotD;
      if (alignPulse) locked   <= 1'b1;
      if (offPhase)   misalign <= 1'b1;
    end
  end

  always_comb begin
    strobe.slotSel = slotQ;
    strobe.capture = (slotQ == LAST_SLOT);
    strobe.emit    = locked && (int'(slotQ) < NUM_OBJ);
    strobe.start   = locked && (slotQ == '0);
  end
endmodule

// File: rtl/tob_slot_datapath.sv
module tob_slot_datapath
  import tob_slot_pkg::*;
#(
  parameter int NUM_OBJ = 5,
  parameter int OBJ_W   = 32,
  parameter int BCN_W   = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slot_strobe_t             strobe,
  input  logic [NUM_OBJ*OBJ_W-1:0] objData,
  input  logic [NUM_OBJ-1:0]       objEmpty,
  input  logic [BCN_W-1:0]         bcnIn,
  output logic [OBJ_W-1:0]         tobData,
  output logic                     tobValid,
  output logic                     tobStart,
  output logic [BCN_W-1:0]         bcnOut
);
  logic [NUM_OBJ-1:0][OBJ_W-1:0] holdObj;
  logic [NUM_OBJ-1:0]            holdEmpty;

  for (genvar k = 0; k < NUM_OBJ; k++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdObj[k]   <= '0;
        holdEmpty[k] <= 1'b1;
      end else if (strobe.capture) begin
        holdObj[k]   <= objData[k*OBJ_W +: OBJ_W];
        holdEmpty[k] <= objEmpty[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               bcnOut <= '0;
    else if (strobe.capture) bcnOut <= bcnIn;
  end

  always_comb begin
    tobData  = '0;
    tobValid = 1'b0;
    for (int k = 0; k < NUM_OBJ; k++) begin
      if (strobe.emit && strobe.slotSel == SLOT_W'(k) && !holdEmpty[k]) begin
        tobData  = holdObj[k];
        tobValid = 1'b1;
      end
    end
  end

  assign tobStart = strobe.start;
endmodule

// File: rtl/tob_slot_serializer.sv
module tob_slot_serializer
  import tob_slot_pkg::*;
#(
  parameter int NUM_OBJ     = 5,
  parameter int OBJ_W       = 32,
  parameter int BCN_W       = 12,
  parameter int ALIGN_PHASE = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     alignPulse,
  input  logic [NUM_OBJ*OBJ_W-1:0] objData,
  input  logic [NUM_OBJ-1:0]       objEmpty,
  input  logic [BCN_W-1:0]         bcnIn,
  output logic [OBJ_W-1:0]         tobData,
  output logic                     tobValid,
  output logic                     tobStart,
  output logic [SLOT_W-1:0]        slotIdx,
  output logic [BCN_W-1:0]         bcnOut,
  output logic                     locked,
  output logic                     misalign
);
  slot_strobe_t strobe;

  tob_slot_ctrl #(
    .NUM_OBJ(NUM_OBJ),
    .ALIGN_PHASE(ALIGN_PHASE)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .alignPulse(alignPulse),
    .strobe(strobe),
    .locked(locked),
    .misalign(misalign)
  );

  tob_slot_datapath #(
    .NUM_OBJ(NUM_OBJ),
    .OBJ_W(OBJ_W),
    .BCN_W(BCN_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .objData(objData),
    .objEmpty(objEmpty),
    .bcnIn(bcnIn),
    .tobData(tobData),
    .tobValid(tobValid),
    .tobStart(tobStart),
    .bcnOut(bcnOut)
  );

  assign slotIdx = strobe.slotSel;
endmodule

// File: rtl/tob_slot_serializer_chk.sv
module tob_slot_serializer_chk
  import tob_slot_pkg::*;
#(
  parameter int OBJ_W       = 32,
  parameter int BCN_W       = 12,
  parameter int ALIGN_PHASE = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              alignPulse,
  input logic [OBJ_W-1:0]  tobData,
  input logic              tobValid,
  input logic              tobStart,
  input logic [SLOT_W-1:0] slotIdx,
  input logic [BCN_W-1:0]  bcnOut,
  input logic              locked,
  input logic              misalign
);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SLOT_W-1:0] ALIGN_NEXT = SLOT_W'((ALIGN_PHASE + 1) % FRAME_SLOTS);

  a_r3_slot_advance: assert property (@(posedge clk) disable iff (!rstN)
    !alignPulse |=> slotIdx == (($past(slotIdx) == LAST_SLOT) ? '0 : $past(slotIdx) + SLOT_W'(1)));

  a_r3_align_force: assert property (@(posedge clk) disable iff (!rstN)
    alignPulse |=> slotIdx == ALIGN_NEXT);

  a_r5_idle_slots: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx >= SLOT_W'(5)) |-> (!tobValid && tobData == '0));

  a_r2_quiet_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (!tobValid && !tobStart));

  a_r7_single_start: assert property (@(posedge clk) disable iff (!rstN)
    tobStart |=> !tobStart);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    misalign |=> misalign);

  a_r11_first_lock_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> !misalign);

  a_r9_bcn_frame_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bcnOut) |-> slotIdx == '0);
endmodule

bind tob_slot_serializer tob_slot_serializer_chk #(
  .OBJ_W(OBJ_W),
  .BCN_W(BCN_W),
  .ALIGN_PHASE(ALIGN_PHASE)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .alignPulse(alignPulse),
  .tobData(tobData),
  .tobValid(tobValid),
  .tobStart(tobStart),
  .slotIdx(slotIdx),
  .bcnOut(bcnOut),
  .locked(locked),
  .misalign(misalign)
);

// File: tb/tob_slot_serializer_bench.sv
module tob_slot_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_OBJ = 5;
  localparam int OBJ_W = 32;
  localparam int BCN_W = 12;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     alignPulse = 1'b0;
  logic [NUM_OBJ*OBJ_W-1:0] objData = '0;
  logic [NUM_OBJ-1:0]       objEmpty = '0;
  logic [BCN_W-1:0]         bcnIn = '0;
  logic [OBJ_W-1:0]         tobData;
  logic                     tobValid;
  logic                     tobStart;
  logic [2:0]               slotIdx;
  logic [BCN_W-1:0]         bcnOut;
  logic                     locked;
  logic                     misalign;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tob_slot_serializer u_tob_slot_serializer (
    .clk(clk), .rstN(rstN), .alignPulse(alignPulse),
    .objData(objData), .objEmpty(objEmpty), .bcnIn(bcnIn),
    .tobData(tobData), .tobValid(tobValid), .tobStart(tobStart),
    .slotIdx(slotIdx), .bcnOut(bcnOut), .locked(locked), .misalign(misalign)
  );

  function automatic logic [OBJ_W-1:0] objVal(input int seed, input int k);
    return OBJ_W'(32'h1000_0000 * (seed + 1) + 32'h11 * (k + 1));
  endfunction

  function automatic logic [BCN_W-1:0] bcnVal(input int seed);
    return BCN_W'(12'h100 + seed * 12'h23);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic loadInputs(input int seed, input logic [NUM_OBJ-1:0] mask);
    for (int k = 0; k < NUM_OBJ; k++) objData[k*OBJ_W +: OBJ_W] = objVal(seed, k);
    objEmpty = mask;
    bcnIn    = bcnVal(seed);
  endtask

  task automatic stepToSlot(input int s);
    for (int i = 0; i < 8 && int'(slotIdx) != s; i++) step();
    check("R3 reach slot", 64'(slotIdx), 64'(s));
  endtask

  // Called in slot 6; checks the seven slots of the next frame.
  task automatic expectFrame(input int seed, input logic [NUM_OBJ-1:0] mask,
                             input int disturbSeed);
    for (int s = 0; s < 7; s++) begin
      step();
      check("R3 slot order", 64'(slotIdx), 64'(s));
      check("R7 start in slot 0 only", 64'(tobStart), 64'(s == 0));
      check("R9 bcn with frame", 64'(bcnOut), 64'(bcnVal(seed)));
      if (s < NUM_OBJ) begin
        if (mask[s]) begin
          check("R6 empty slot valid", 64'(tobValid), 64'(0));
          check("R6 empty slot data", 64'(tobData), 64'(0));
        end else begin
          check("R4 object valid", 64'(tobValid), 64'(1));
          check("R4 object order", 64'(tobData), 64'(objVal(seed, s)));
        end
      end else begin
        check("R5 idle valid", 64'(tobValid), 64'(0));
        check("R5 idle data", 64'(tobData), 64'(0));
      end
      if (s == 0 && disturbSeed >= 0) loadInputs(disturbSeed, '1);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    loadInputs(1, '0);
    repeat (4) step();
    check("R1 valid", 64'(tobValid), 64'(0));
    check("R1 start", 64'(tobStart), 64'(0));
    check("R1 locked", 64'(locked), 64'(0));
    check("R1 misalign", 64'(misalign), 64'(0));
    check("R1 data", 64'(tobData), 64'(0));
    check("R1 bcn", 64'(bcnOut), 64'(0));
    rstN = 1'b1;
    step();
    check("R1 after release valid", 64'(tobValid), 64'(0));
    check("R1 after release bcn", 64'(bcnOut), 64'(0));
  endtask

  task automatic t_unlocked();
    for (int i = 0; i < 15; i++) begin
      step();
      check("R2 no start unlocked", 64'(tobStart), 64'(0));
      check("R2 no valid unlocked", 64'(tobValid), 64'(0));
    end
  endtask

  task automatic t_first_lock();
    stepToSlot(3);
    alignPulse = 1'b1;
    step();
    alignPulse = 1'b0;
    check("R3 align forces slot 6", 64'(slotIdx), 64'(6));
    check("R11 locked after first strobe", 64'(locked), 64'(1));
    check("R11 first strobe no misalign", 64'(misalign), 64'(0));
    loadInputs(2, '0);
    expectFrame(2, '0, -1);
  endtask

  task automatic t_hold();
    loadInputs(3, '0);
    expectFrame(3, '0, 4);     // R8: inputs swapped in slot 0
    expectFrame(4, '1, -1);    // R8: swapped values appear next frame
  endtask

  task automatic t_empty();
    loadInputs(5, 5'b01010);
    expectFrame(5, 5'b01010, -1);
  endtask

  task automatic t_on_phase();
    stepToSlot(5);
    alignPulse = 1'b1;
    step();
    alignPulse = 1'b0;
    check("R10 on-phase slot", 64'(slotIdx), 64'(6));
    check("R10 on-phase no misalign", 64'(misalign), 64'(0));
    expectFrame(5, 5'b01010, -1);
  endtask

  task automatic t_off_phase();
    stepToSlot(2);
    alignPulse = 1'b1;
    step();
    alignPulse = 1'b0;
    check("R10 off-phase realigned", 64'(slotIdx), 64'(6));
    check("R10 off-phase flag", 64'(misalign), 64'(1));
    loadInputs(6, '0);
    expectFrame(6, '0, -1);
    check("R10 flag sticky", 64'(misalign), 64'(1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_unlocked();
    t_first_lock();
    t_hold();
    t_empty();
    t_on_phase();
    t_off_phase();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule